// File: doc/BRIEF.md
# Sticky Link Status Register

This block is the software-visible status and interrupt-control register pair of a serial radio-link receiver. It turns the receiver's live indications into a readable status word. Those indications are loss of signal, frame synchronization, hyperframe and node-frame sync, and a line-code-violation alarm. It also keeps sticky copies of four events. A sticky copy stays set until software reads the status word, and that read clears it. A short pulse such as the periodic radio-frame marker therefore cannot be missed between two polls. The same rule means a value caught while the link is still coming up is still there on the first read. Software reads twice to see the settled state.

A single-cycle bus port reaches two words. The control word holds a global interrupt enable and an enable for link-received reset requests. The status word mixes live and sticky bits. The interrupt output is raised when the global enable is on and any source is active. The sources are any set sticky bit, or a reset request while its enable is on.

Top module: `lnk_stat_regs`

## Requirements
- R1: After a synchronous active-high reset, the read data, the interrupt output, the control word and every sticky bit are zero.
- R2: A read of offset 0x4 returns the live inputs at fixed positions: bit 0 loss of signal, bit 1 receiver frame sync, bit 2 hyperframe sync, bit 3 node-frame sync, bit 5 violation-count alarm.
- R3: Status bits 4, 7:6 and 31:12 always read as zero.
- R4: Sticky bits sit at status bits 8 (loss of signal), 9 (receiver frame sync), 10 (clock mismatch) and 11 (radio-frame pulse). Each is set at the clock edge where its source is high, and it stays set until a status read.
- R5: A status read returns the sticky bits as they were before the read, then clears every sticky bit whose source is low in that cycle.
- R6: A sticky bit whose source is high in the same cycle as a clearing status read stays set.
- R7: Writing offset 0x0 stores data bits 0 (global interrupt enable) and 1 (reset-request interrupt enable). Reading 0x0 returns them, with all other bits zero.
- R8: Writes to offset 0x4 change no register state.
- R9: The interrupt output equals the global enable ANDed with the OR of all sticky bits and of the reset-request input gated by control bit 1.
- R10: Read data is registered. It updates at the edge after a read request and holds at other times. A read of any offset other than 0x0 or 0x4 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| los_i | input | 1 | Live loss of signal |
| rx_sync_i | input | 1 | Receiver frame sync achieved |
| hfn_sync_i | input | 1 | Hyperframe sync achieved |
| bfn_sync_i | input | 1 | Node-frame sync achieved |
| lcv_alarm_i | input | 1 | Violation-count loss alarm |
| clk_mismatch_i | input | 1 | Receive/system clock mismatch flag |
| frame_pulse_i | input | 1 | Periodic radio-frame pulse |
| reset_req_i | input | 1 | Reset request received over the link |
| irq_o | output | 1 | Interrupt output |

## Verification
Single-cycle frame pulses are followed by idle cycles and then two reads. These show whether an event is latched, whether it survives until the read, and whether the first read clears it. A pulse placed exactly on the clearing read tells a set-wins update from a clear-wins one. Walking levels across the live inputs separate the live bits from their sticky copies and expose any misplaced field. A long run of random inputs, enables and accesses checks the interrupt gating against a behavioural model every cycle.

// File: rtl/lnk_stat_pkg.sv
package lnk_stat_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int N_HOLD   = 4;
    localparam int HOLD_LSB = 8;
    localparam int CTRL_W   = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } sel_e;

    typedef struct packed {
        logic lcv_alarm;
        logic bfn;
        logic hfn;
        logic rx_sync;
        logic los;
    } live_t;

    // bit 0 of the packed vector is the loss-of-signal copy
    typedef struct packed {
        logic frame;
        logic mismatch;
        logic rx_sync;
        logic los;
    } hold_t;

    typedef struct packed {
        logic rst_req_en;
        logic glb_en;
    } ctrl_t;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == OFS_CTRL)      return SEL_CTRL;
        else if (a == OFS_STAT) return SEL_STAT;
        else                    return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input live_t l, input hold_t h);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = l.los;
        w[1] = l.rx_sync;
        w[2] = l.hfn;
        w[3] = l.bfn;
        w[5] = l.lcv_alarm;
        w[HOLD_LSB +: N_HOLD] = h;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_W-1:0] = c;
        return w;
    endfunction

endpackage

// File: rtl/lnk_hold_bank.sv
module lnk_hold_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] hold_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (set_i[i])
                q <= 1'b1;
            else if (clr_i)
                q <= 1'b0;
        end
        assign hold_o[i] = q;
    end
endmodule

// File: rtl/lnk_ctrl_reg.sv
module lnk_ctrl_reg
    import lnk_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_o <= '0;
        else if (wr_i)
            ctrl_o <= ctrl_t'(wdata_i);
    end
endmodule

// File: rtl/lnk_irq_gen.sv
module lnk_irq_gen
    import lnk_stat_pkg::*;
(
    input  ctrl_t ctrl_i,
    input  hold_t hold_i,
    input  logic  rst_req_i,
    output logic  irq_o
);
    logic any_src;
    always_comb begin
        any_src = (|hold_i) | (ctrl_i.rst_req_en & rst_req_i);
        irq_o   = ctrl_i.glb_en & any_src;
    end
endmodule

// File: rtl/lnk_stat_regs.sv
module lnk_stat_regs
    import lnk_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              los_i,
    input  logic              rx_sync_i,
    input  logic              hfn_sync_i,
    input  logic              bfn_sync_i,
    input  logic              lcv_alarm_i,
    input  logic              clk_mismatch_i,
    input  logic              frame_pulse_i,
    input  logic              reset_req_i,
    output logic              irq_o
);
    sel_e  sel;
    live_t live;
    hold_t hold_set;
    hold_t hold_q;
    ctrl_t ctrl_q;
    logic  stat_rd;
    logic  ctrl_wr;

    always_comb begin
        sel       = decode(bus_addr);
        stat_rd   = bus_rd & (sel == SEL_STAT);
        ctrl_wr   = bus_wr & (sel == SEL_CTRL);
        live      = '{lcv_alarm: lcv_alarm_i, bfn: bfn_sync_i, hfn: hfn_sync_i,
                      rx_sync: rx_sync_i, los: los_i};
        hold_set  = '{frame: frame_pulse_i, mismatch: clk_mismatch_i,
                      rx_sync: rx_sync_i, los: los_i};
    end

    logic [N_HOLD-1:0] hold_vec;

    lnk_hold_bank #(.N(N_HOLD)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .set_i  (hold_set),
        .clr_i  (stat_rd),
        .hold_o (hold_vec)
    );
    assign hold_q = hold_t'(hold_vec);

    lnk_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ctrl_wr),
        .wdata_i (bus_wdata[CTRL_W-1:0]),
        .ctrl_o  (ctrl_q)
    );

    lnk_irq_gen u_irq (
        .ctrl_i    (ctrl_q),
        .hold_i    (hold_q),
        .rst_req_i (reset_req_i),
        .irq_o     (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd) begin
            unique case (sel)
                SEL_CTRL: bus_rdata <= pack_ctrl(ctrl_q);
                SEL_STAT: bus_rdata <= pack_status(live, hold_q);
                default:  bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/lnk_stat_chk.sv
module lnk_stat_chk
    import lnk_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              frame_pulse_i,
    input logic              clk_mismatch_i,
    input logic              los_i,
    input logic              rx_sync_i,
    input logic [N_HOLD-1:0] hold_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              irq_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && hold_q == '0 && ctrl_q == '0));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[DATA_W-1:HOLD_LSB+N_HOLD] == '0 && bus_rdata[7:6] == 2'b00 && !bus_rdata[4]));

    a_r4_frame_sets: assert property (@(posedge clk) disable iff (rst)
        frame_pulse_i |=> hold_q[3]);

    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_STAT && clk_mismatch_i) |=> hold_q[2]);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_STAT && !frame_pulse_i && !clk_mismatch_i && !los_i && !rx_sync_i)
        |=> hold_q == '0);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[0] |-> !irq_o);

    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind lnk_stat_regs lnk_stat_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_rd         (bus_rd),
    .bus_rdata      (bus_rdata),
    .frame_pulse_i  (frame_pulse_i),
    .clk_mismatch_i (clk_mismatch_i),
    .los_i          (los_i),
    .rx_sync_i      (rx_sync_i),
    .hold_q         (hold_vec),
    .ctrl_q         (ctrl_q),
    .irq_o          (irq_o)
);

// File: tb/test_lnk_stat_regs.sv
module test_lnk_stat_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        los_i = 0, rx_sync_i = 0, hfn_sync_i = 0, bfn_sync_i = 0;
    logic        lcv_alarm_i = 0, clk_mismatch_i = 0, frame_pulse_i = 0, reset_req_i = 0;
    logic        irq_o;

    int vectors = 0;
    int errs    = 0;

    // behavioural reference state
    bit [3:0]  m_hold  = '0;
    bit [1:0]  m_ctrl  = '0;
    bit [31:0] m_rdata = '0;

    always #2.5 clk = ~clk;

    lnk_stat_regs i_lnk_stat_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .los_i(los_i), .rx_sync_i(rx_sync_i), .hfn_sync_i(hfn_sync_i),
        .bfn_sync_i(bfn_sync_i), .lcv_alarm_i(lcv_alarm_i),
        .clk_mismatch_i(clk_mismatch_i), .frame_pulse_i(frame_pulse_i),
        .reset_req_i(reset_req_i), .irq_o(irq_o)
    );

    function automatic bit [31:0] status_word();
        bit [31:0] w = 0;
        w[0] = los_i; w[1] = rx_sync_i; w[2] = hfn_sync_i; w[3] = bfn_sync_i;
        w[5] = lcv_alarm_i;
        w[8] = m_hold[0]; w[9] = m_hold[1]; w[10] = m_hold[2]; w[11] = m_hold[3];
        return w;
    endfunction

    task automatic model_edge();
        bit [3:0] src;
        bit       clr;
        if (rst) begin
            m_hold = 0; m_ctrl = 0; m_rdata = 0;
            return;
        end
        src = {frame_pulse_i, clk_mismatch_i, rx_sync_i, los_i};
        clr = bus_rd && bus_addr == 8'h04;
        if (bus_rd) begin
            if (bus_addr == 8'h00)      m_rdata = {30'b0, m_ctrl};
            else if (bus_addr == 8'h04) m_rdata = status_word();
            else                        m_rdata = 0;
        end
        for (int i = 0; i < 4; i++)
            if (src[i]) m_hold[i] = 1;
            else if (clr) m_hold[i] = 0;
        if (bus_wr && bus_addr == 8'h00) m_ctrl = bus_wdata[1:0];
    endtask

    task automatic compare(input string tag);
        bit exp_irq;
        exp_irq = m_ctrl[0] && (m_hold != 0 || (m_ctrl[1] && reset_req_i));
        vectors++;
        if (bus_rdata !== m_rdata || irq_o !== exp_irq) begin
            errs++;
            $display("FAIL %s: rdata=%h exp=%h irq=%b exp=%b", tag, bus_rdata, m_rdata, irq_o, exp_irq);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; bus_addr = 8'h10; bus_wdata = 0;
    endtask

    task automatic rd(input bit [7:0] a, input string tag);
        bus_rd = 1; bus_wr = 0; bus_addr = a;
        cyc(tag);
        idle();
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d, input string tag);
        bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
        cyc(tag);
        idle();
    endtask

    task automatic clear_events();
        los_i = 0; rx_sync_i = 0; clk_mismatch_i = 0; frame_pulse_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc("R1"); cyc("R1"); cyc("R1");
        rst = 0;
        idle();
        cyc("R1");

        // R7: control word
        wr(8'h00, 32'h0000_0003, "R7");
        rd(8'h00, "R7");
        wr(8'h00, 32'hFFFF_FFFC, "R7");
        rd(8'h00, "R7");

        // R2 / R3: walking live levels, each read twice
        los_i = 1; rd(8'h04, "R2"); los_i = 0; rd(8'h04, "R2"); rd(8'h04, "R2");
        hfn_sync_i = 1; rd(8'h04, "R2"); hfn_sync_i = 0;
        bfn_sync_i = 1; rd(8'h04, "R2"); bfn_sync_i = 0;
        lcv_alarm_i = 1; rd(8'h04, "R3"); lcv_alarm_i = 0;
        rx_sync_i = 1; rd(8'h04, "R2"); rx_sync_i = 0; rd(8'h04, "R2"); rd(8'h04, "R3");

        // R4 / R5: single pulses persist until read, then clear
        frame_pulse_i = 1; cyc("R4"); frame_pulse_i = 0;
        cyc("R4"); cyc("R4");
        rd(8'h04, "R5"); rd(8'h04, "R5");
        clk_mismatch_i = 1; cyc("R4"); clk_mismatch_i = 0;
        rd(8'h04, "R5"); rd(8'h04, "R5");

        // R6: event on the clearing read
        frame_pulse_i = 1; cyc("R6"); frame_pulse_i = 0;
        frame_pulse_i = 1; rd(8'h04, "R6"); frame_pulse_i = 0;
        rd(8'h04, "R6"); rd(8'h04, "R6");

        // R8: writes to status ignored
        wr(8'h04, 32'hFFFF_FFFF, "R8");
        rd(8'h04, "R8"); rd(8'h00, "R8");

        // R9: interrupt gating
        frame_pulse_i = 1; cyc("R9"); frame_pulse_i = 0; cyc("R9");
        wr(8'h00, 32'h1, "R9"); cyc("R9");
        rd(8'h04, "R9"); cyc("R9");
        reset_req_i = 1; cyc("R9");
        wr(8'h00, 32'h3, "R9"); cyc("R9");
        reset_req_i = 0; cyc("R9");
        wr(8'h00, 32'h2, "R9"); reset_req_i = 1; cyc("R9"); reset_req_i = 0;

        // R10: unmapped read and hold behaviour
        wr(8'h00, 32'h3, "R10");
        rd(8'h00, "R10"); cyc("R10"); cyc("R10");
        rd(8'h08, "R10"); rd(8'hFF, "R10"); cyc("R10");

        // mixed random traffic
        for (int n = 0; n < 2000; n++) begin
            bit [3:0] k;
            k = 4'($urandom_range(0, 15));
            los_i = ($urandom_range(0, 7) == 0); rx_sync_i = ($urandom_range(0, 3) == 0);
            hfn_sync_i = $urandom_range(0, 1); bfn_sync_i = $urandom_range(0, 1);
            lcv_alarm_i = $urandom_range(0, 1);
            clk_mismatch_i = ($urandom_range(0, 15) == 0);
            frame_pulse_i = ($urandom_range(0, 15) == 0);
            reset_req_i = ($urandom_range(0, 7) == 0);
            bus_rd = k[0] | k[1];
            bus_wr = k[2] & k[3];
            bus_addr = k[1] ? 8'h04 : (k[3] ? 8'h00 : 8'h0C);
            bus_wdata = $urandom;
            cyc("R9");
        end
        idle(); clear_events(); reset_req_i = 0;
        cyc("R5");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule